// File: doc/BRIEF.md
# Corrected Error Repeat Counter

This block is a 64-bit error syndrome register that counts corrected errors. It takes a stream of error reports. Each report carries a severity class and a location syndrome, for example a cache set and way. In single mode every countable report advances one counter. In split mode the first countable report after a clear latches its syndrome as a key. Later reports that carry the same syndrome advance a repeat counter, and every other countable report advances an "other" counter. Each counter has a sticky wrap flag. Together the flags form a level request output, which a later interrupt stage can use.

Software reads the register continuously on `reg_rdata` and writes it with a one-cycle `reg_wr` strobe. Two static inputs choose the layout: a 15-bit (wide) or 7-bit (narrow) counter width, and single or split counting. A third static input decides whether deferred and uncorrected reports count. The report input is a valid/ready stream. The block never applies back-pressure, so `err_ready` is held high and a report is taken on every cycle that `err_valid` is high.

Top module: `cerc_repeat_counter`

## Requirements
- R1: After reset, `reg_rdata` is all zero and `ovf_req` is low.
- R2: In single mode (`cfg_split`=0), each countable report adds one to the counter. The counter sits at bits [46:32] (wide) or [38:32] (narrow). Bits [63:48] read as zero.
- R3: When a counter at its all-ones value is incremented, it wraps to zero and its flag is set to 1. The repeat/single flag is bit 47 (wide) or bit 39 (narrow). The flag and `ovf_req` stay high through further reports until a register write.
- R4: In split mode, the first countable report after a clear increments the repeat counter and latches its syndrome. Each later countable report with an equal syndrome increments the repeat counter, and any other countable report increments the other counter. The other counter sits at bits [62:48] (wide) or [46:40] (narrow).
- R5: The other counter's wrap flag is bit 63 (wide) or bit 47 (narrow) and behaves as in R3.
- R6: `err_cls` encodes 0 as corrected, 1 as deferred, and 2 or 3 as uncorrected. Corrected reports always count. Deferred and uncorrected reports count only when `cfg_count_all`=1, and otherwise leave both counters unchanged.
- R7: Writing zero clears both counters and both flags, and drops `ovf_req` on the next cycle. Any write whose repeat-counter field is zero also forgets the latched key, so the next countable report is treated as a first report.
- R8: When a write and a countable report arrive in the same cycle, the written counter values are kept and the increment is lost.
- R9: Bits [SYND_W-1:0] (default [15:0]) show the syndrome of the most recent accepted report while `stat_valid`=1 and read as zero while it is 0. Writes never change this field.
- R10: `err_ready` is always 1. A report's effect appears on `reg_rdata` in the cycle after it is accepted.
- R11: Counter fields and flags can be written to any value and read back unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_narrow | input | 1 | 1: 7-bit counter layout, 0: 15-bit layout |
| cfg_split | input | 1 | 1: repeat/other split counting, 0: single counter |
| cfg_count_all | input | 1 | 1: deferred and uncorrected reports also count |
| stat_valid | input | 1 | Status valid bit; controls visibility of the recent-syndrome field |
| err_valid | input | 1 | Error report valid |
| err_ready | output | 1 | Error report ready (always 1) |
| err_cls | input | 2 | Report class: 0 corrected, 1 deferred, 2/3 uncorrected |
| err_synd | input | SYND_W | Location syndrome of the report |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 64 | Register write data |
| reg_rdata | output | 64 | Register read data |
| ovf_req | output | 1 | High while any active wrap flag is set |

## Verification
The hardest states to reach are the counter wraps: a wide counter needs 32768 reports before it wraps. The bench avoids this by writing a counter to its all-ones value through the register port and then sending one more report. It does this for the repeat and other counters in both layouts. The write/report collision needs a report and a write driven on the same clock edge, and the bench does this from a single task. Forgetting the key is only visible indirectly. The bench shows it by sending a report with a new syndrome after a zero write and checking that the report lands in the repeat counter.

// File: rtl/cerc_pkg.sv
package cerc_pkg;
  // Report severity codes
  typedef enum logic [1:0] {
    CLS_CORR   = 2'd0,
    CLS_DEFER  = 2'd1,
    CLS_UNCORR = 2'd2,
    CLS_RSVD   = 2'd3
  } err_cls_e;

  localparam int CNT_W_WIDE   = 15;
  localparam int CNT_W_NARROW = 7;
  localparam int CNT_PAD      = CNT_W_WIDE - CNT_W_NARROW;
  localparam int REG_W        = 64;

  // Field positions, decoded by software
  localparam int REP_LSB       = 32;
  localparam int W_REP_FLAG    = REP_LSB + CNT_W_WIDE;       // 47
  localparam int W_OTH_LSB     = W_REP_FLAG + 1;             // 48
  localparam int W_OTH_FLAG    = W_OTH_LSB + CNT_W_WIDE;     // 63
  localparam int N_REP_FLAG    = REP_LSB + CNT_W_NARROW;     // 39
  localparam int N_OTH_LSB     = N_REP_FLAG + 1;             // 40
  localparam int N_OTH_FLAG    = N_OTH_LSB + CNT_W_NARROW;   // 47

  localparam int NUM_CTR = 2;   // index 0: repeat/single, 1: other
endpackage

// File: rtl/cerc_counter.sv
module cerc_counter
  import cerc_pkg::*;
#(
  parameter int W  = CNT_W_WIDE,
  parameter int NW = CNT_W_NARROW
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         narrow,
  input  logic         inc,
  input  logic         wr_en,
  input  logic [W-1:0] wr_cnt,
  input  logic         wr_flag,
  output logic [W-1:0] cnt,
  output logic         flag
);
  localparam int PAD = W - NW;

  logic [W-1:0] mask;
  logic         at_top;

  assign mask   = narrow ? {{PAD{1'b0}}, {NW{1'b1}}} : {W{1'b1}};
  assign at_top = ((cnt & mask) == mask);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt  <= '0;
      flag <= 1'b0;
    end else if (wr_en) begin
      cnt  <= wr_cnt & mask;
      flag <= wr_flag;
    end else if (inc) begin
      cnt <= (cnt + 1'b1) & mask;
      if (at_top) flag <= 1'b1;
    end
  end
endmodule

// File: rtl/cerc_route.sv
module cerc_route
  import cerc_pkg::*;
#(
  parameter int SYND_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              split,
  input  logic              count_all,
  input  logic              err_take,
  input  logic [1:0]        cls,
  input  logic [SYND_W-1:0] synd,
  input  logic              key_clr,
  output logic              inc_rep,
  output logic              inc_oth,
  output logic [SYND_W-1:0] last_synd
);
  logic [SYND_W-1:0] key;
  logic              key_vld;
  logic              countable;
  logic              hit;

  assign countable = err_take && ((err_cls_e'(cls) == CLS_CORR) || count_all);
  assign hit       = !key_vld || (synd == key);
  assign inc_rep   = countable && (!split || hit);
  assign inc_oth   = countable && split && !hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      key_vld   <= 1'b0;
      key       <= '0;
      last_synd <= '0;
    end else begin
      if (err_take) last_synd <= synd;
      if (key_clr) begin
        key_vld <= 1'b0;
      end else if (countable && split && !key_vld) begin
        key_vld <= 1'b1;
        key     <= synd;
      end
    end
  end
endmodule

// File: rtl/cerc_regmap.sv
module cerc_regmap
  import cerc_pkg::*;
#(
  parameter int SYND_W = 16
) (
  input  logic                  narrow,
  input  logic                  split,
  input  logic                  stat_valid,
  input  logic [CNT_W_WIDE-1:0] rep_cnt,
  input  logic                  rep_flag,
  input  logic [CNT_W_WIDE-1:0] oth_cnt,
  input  logic                  oth_flag,
  input  logic [SYND_W-1:0]     last_synd,
  input  logic [REG_W-1:0]      wdata,
  output logic [REG_W-1:0]      rdata,
  output logic [CNT_W_WIDE-1:0] w_rep_cnt,
  output logic                  w_rep_flag,
  output logic [CNT_W_WIDE-1:0] w_oth_cnt,
  output logic                  w_oth_flag
);
  // Write-side field extraction
  always_comb begin
    if (narrow) begin
      w_rep_cnt  = {{CNT_PAD{1'b0}}, wdata[REP_LSB +: CNT_W_NARROW]};
      w_rep_flag = wdata[N_REP_FLAG];
      w_oth_cnt  = {{CNT_PAD{1'b0}}, wdata[N_OTH_LSB +: CNT_W_NARROW]};
      w_oth_flag = wdata[N_OTH_FLAG];
    end else begin
      w_rep_cnt  = wdata[REP_LSB +: CNT_W_WIDE];
      w_rep_flag = wdata[W_REP_FLAG];
      w_oth_cnt  = wdata[W_OTH_LSB +: CNT_W_WIDE];
      w_oth_flag = wdata[W_OTH_FLAG];
    end
  end

  // Read-side packing
  always_comb begin
    rdata = '0;
    if (narrow) begin
      rdata[REP_LSB +: CNT_W_NARROW] = rep_cnt[CNT_W_NARROW-1:0];
      rdata[N_REP_FLAG]              = rep_flag;
      if (split) begin
        rdata[N_OTH_LSB +: CNT_W_NARROW] = oth_cnt[CNT_W_NARROW-1:0];
        rdata[N_OTH_FLAG]                = oth_flag;
      end
    end else begin
      rdata[REP_LSB +: CNT_W_WIDE] = rep_cnt;
      rdata[W_REP_FLAG]            = rep_flag;
      if (split) begin
        rdata[W_OTH_LSB +: CNT_W_WIDE] = oth_cnt;
        rdata[W_OTH_FLAG]              = oth_flag;
      end
    end
    if (stat_valid) rdata[SYND_W-1:0] = last_synd;
  end
endmodule

// File: rtl/cerc_repeat_counter.sv
module cerc_repeat_counter
  import cerc_pkg::*;
#(
  parameter int SYND_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_narrow,
  input  logic              cfg_split,
  input  logic              cfg_count_all,
  input  logic              stat_valid,
  input  logic              err_valid,
  output logic              err_ready,
  input  logic [1:0]        err_cls,
  input  logic [SYND_W-1:0] err_synd,
  input  logic              reg_wr,
  input  logic [63:0]       reg_wdata,
  output logic [63:0]       reg_rdata,
  output logic              ovf_req
);
  logic [CNT_W_WIDE-1:0] cnt    [NUM_CTR];
  logic                  flg    [NUM_CTR];
  logic [CNT_W_WIDE-1:0] wcnt   [NUM_CTR];
  logic                  wflg   [NUM_CTR];
  logic                  inc    [NUM_CTR];
  logic                  wr_en  [NUM_CTR];
  logic [SYND_W-1:0]     last_synd;
  logic                  key_clr;

  assign err_ready = 1'b1;
  assign key_clr   = reg_wr && (wcnt[0] == '0);
  assign wr_en[0]  = reg_wr;
  assign wr_en[1]  = reg_wr && cfg_split;

  cerc_route #(.SYND_W(SYND_W)) u_route (
    .clk       (clk),
    .rst_n     (rst_n),
    .split     (cfg_split),
    .count_all (cfg_count_all),
    .err_take  (err_valid && err_ready),
    .cls       (err_cls),
    .synd      (err_synd),
    .key_clr   (key_clr),
    .inc_rep   (inc[0]),
    .inc_oth   (inc[1]),
    .last_synd (last_synd)
  );

  for (genvar g = 0; g < NUM_CTR; g++) begin : g_ctr
    cerc_counter #(.W(CNT_W_WIDE), .NW(CNT_W_NARROW)) u_ctr (
      .clk     (clk),
      .rst_n   (rst_n),
      .narrow  (cfg_narrow),
      .inc     (inc[g]),
      .wr_en   (wr_en[g]),
      .wr_cnt  (wcnt[g]),
      .wr_flag (wflg[g]),
      .cnt     (cnt[g]),
      .flag    (flg[g])
    );
  end

  cerc_regmap #(.SYND_W(SYND_W)) u_map (
    .narrow     (cfg_narrow),
    .split      (cfg_split),
    .stat_valid (stat_valid),
    .rep_cnt    (cnt[0]),
    .rep_flag   (flg[0]),
    .oth_cnt    (cnt[1]),
    .oth_flag   (flg[1]),
    .last_synd  (last_synd),
    .wdata      (reg_wdata),
    .rdata      (reg_rdata),
    .w_rep_cnt  (wcnt[0]),
    .w_rep_flag (wflg[0]),
    .w_oth_cnt  (wcnt[1]),
    .w_oth_flag (wflg[1])
  );

  assign ovf_req = flg[0] || (cfg_split && flg[1]);
endmodule

// File: rtl/cerc_chk.sv
module cerc_chk #(
  parameter int SYND_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_split,
  input logic              cfg_narrow,
  input logic              cfg_count_all,
  input logic              stat_valid,
  input logic              err_valid,
  input logic              err_ready,
  input logic [1:0]        err_cls,
  input logic              reg_wr,
  input logic [63:0]       reg_wdata,
  input logic [63:0]       reg_rdata,
  input logic              ovf_req
);
  p_ready_r10: assert property (@(posedge clk) disable iff (!rst_n) err_ready);

  p_clear_irq_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_wdata == 64'd0) |=> !ovf_req);

  p_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_req && !reg_wr) |=> (!$stable(cfg_split) || ovf_req));

  p_hidden_synd_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_valid |-> (reg_rdata[SYND_W-1:0] == '0));

  p_excluded_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (err_valid && err_cls != 2'd0 && !cfg_count_all && !reg_wr) |=>
      (!$stable(cfg_narrow) || !$stable(cfg_split) || $stable(reg_rdata[63:32])));

  p_single_upper_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_split |-> (reg_rdata[63:48] == 16'd0));
endmodule

bind cerc_repeat_counter cerc_chk #(.SYND_W(SYND_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cfg_split     (cfg_split),
  .cfg_narrow    (cfg_narrow),
  .cfg_count_all (cfg_count_all),
  .stat_valid    (stat_valid),
  .err_valid     (err_valid),
  .err_ready     (err_ready),
  .err_cls       (err_cls),
  .reg_wr        (reg_wr),
  .reg_wdata     (reg_wdata),
  .reg_rdata     (reg_rdata),
  .ovf_req       (ovf_req)
);

// File: tb/sim_cerc_repeat_counter.sv
`timescale 1ns/1ps
module sim_cerc_repeat_counter;
  localparam int SW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_narrow = 1'b0, cfg_split = 1'b0, cfg_count_all = 1'b0;
  logic          stat_valid = 1'b0;
  logic          err_valid = 1'b0;
  logic          err_ready;
  logic [1:0]    err_cls = 2'd0;
  logic [SW-1:0] err_synd = '0;
  logic          reg_wr = 1'b0;
  logic [63:0]   reg_wdata = '0;
  logic [63:0]   reg_rdata;
  logic          ovf_req;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;   // 125 MHz

  cerc_repeat_counter #(.SYND_W(SW)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_narrow(cfg_narrow), .cfg_split(cfg_split),
    .cfg_count_all(cfg_count_all), .stat_valid(stat_valid),
    .err_valid(err_valid), .err_ready(err_ready), .err_cls(err_cls),
    .err_synd(err_synd), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .ovf_req(ovf_req)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic send(input logic [1:0] cls, input logic [SW-1:0] s);
    err_valid = 1'b1; err_cls = cls; err_synd = s;
    @(negedge clk);
    err_valid = 1'b0;
  endtask

  task automatic wr(input logic [63:0] d);
    reg_wr = 1'b1; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic mode(input logic nar, input logic spl);
    wr(64'd0);
    cfg_narrow = nar; cfg_split = spl;
    @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R1 rdata", reg_rdata, 64'd0);
    chk("R1 ovf_req", {63'd0, ovf_req}, 64'd0);
    chk("R10 err_ready", {63'd0, err_ready}, 64'd1);
  endtask

  task automatic t_single;
    mode(1'b0, 1'b0);
    send(2'd0, 16'h1); send(2'd0, 16'h2);
    chk("R10 one cycle later", reg_rdata, 64'd2 << 32);
    send(2'd0, 16'h3);
    chk("R2 wide single", reg_rdata, 64'd3 << 32);
    mode(1'b1, 1'b0);
    send(2'd0, 16'h1); send(2'd0, 16'h1);
    chk("R2 narrow single", reg_rdata, 64'd2 << 32);
  endtask

  task automatic t_wrap;
    mode(1'b1, 1'b0);
    wr(64'h7F << 32);
    send(2'd0, 16'h5);
    chk("R3 narrow wrap", reg_rdata, 64'd1 << 39);
    chk("R3 ovf_req", {63'd0, ovf_req}, 64'd1);
    send(2'd0, 16'h5);
    chk("R3 sticky", reg_rdata, (64'd1 << 39) | (64'd1 << 32));
    wr(64'd0);
    chk("R7 zero write", reg_rdata, 64'd0);
    chk("R7 ovf_req drops", {63'd0, ovf_req}, 64'd0);
    mode(1'b0, 1'b0);
    wr(64'h7FFF << 32);
    send(2'd0, 16'h5);
    chk("R3 wide wrap", reg_rdata, 64'd1 << 47);
    wr(64'd0);
  endtask

  task automatic t_split;
    mode(1'b0, 1'b1);
    send(2'd0, 16'hA); send(2'd0, 16'hA); send(2'd0, 16'hB);
    send(2'd0, 16'hA); send(2'd0, 16'hC);
    chk("R4 wide split", reg_rdata, (64'd2 << 48) | (64'd3 << 32));
    mode(1'b1, 1'b1);
    send(2'd0, 16'hA); send(2'd0, 16'hB); send(2'd0, 16'hB);
    chk("R4 narrow split", reg_rdata, (64'd2 << 40) | (64'd1 << 32));
  endtask

  task automatic t_other_wrap;
    mode(1'b1, 1'b1);
    send(2'd0, 16'hA);
    wr((64'h7F << 40) | (64'd1 << 32));
    send(2'd0, 16'hB);
    chk("R5 narrow other wrap", reg_rdata, (64'd1 << 47) | (64'd1 << 32));
    mode(1'b0, 1'b1);
    send(2'd0, 16'hA);
    wr((64'h7FFF << 48) | (64'd1 << 32));
    send(2'd0, 16'hD);
    chk("R5 wide other wrap", reg_rdata, (64'd1 << 63) | (64'd1 << 32));
    chk("R5 ovf_req", {63'd0, ovf_req}, 64'd1);
    wr(64'd0);
  endtask

  task automatic t_class;
    mode(1'b0, 1'b0);
    cfg_count_all = 1'b0;
    send(2'd1, 16'h1); send(2'd2, 16'h1); send(2'd3, 16'h1);
    chk("R6 excluded classes", reg_rdata, 64'd0);
    send(2'd0, 16'h1);
    chk("R6 corrected counts", reg_rdata, 64'd1 << 32);
    cfg_count_all = 1'b1;
    send(2'd1, 16'h1); send(2'd2, 16'h1);
    chk("R6 count_all", reg_rdata, 64'd3 << 32);
    cfg_count_all = 1'b0;
  endtask

  task automatic t_key_clear;
    mode(1'b0, 1'b1);
    send(2'd0, 16'hA);
    wr(64'd0);
    send(2'd0, 16'hB);
    chk("R7 key forgotten", reg_rdata, 64'd1 << 32);
  endtask

  task automatic t_priority;
    mode(1'b0, 1'b0);
    send(2'd0, 16'h1); send(2'd0, 16'h1);
    err_valid = 1'b1; err_cls = 2'd0; err_synd = 16'h1;
    reg_wr = 1'b1; reg_wdata = 64'd9 << 32;
    @(negedge clk);
    err_valid = 1'b0; reg_wr = 1'b0;
    chk("R8 write wins", reg_rdata, 64'd9 << 32);
  endtask

  task automatic t_readback;
    mode(1'b0, 1'b1);
    wr((64'h1234 << 48) | (64'h0567 << 32));
    chk("R11 readback", reg_rdata, (64'h1234 << 48) | (64'h0567 << 32));
    wr(64'd0);
  endtask

  task automatic t_synd;
    mode(1'b0, 1'b0);
    stat_valid = 1'b0;
    send(2'd1, 16'h1234);
    chk("R9 hidden", reg_rdata, 64'd0);
    stat_valid = 1'b1;
    #1;
    chk("R9 visible", reg_rdata, 64'h1234);
    wr(64'hFFFF);
    chk("R9 write ignored", reg_rdata, 64'h1234);
    stat_valid = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_single;
    t_wrap;
    t_split;
    t_other_wrap;
    t_class;
    t_key_clear;
    t_priority;
    t_readback;
    t_synd;
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule